// File: doc/BRIEF.md
# PCI Target Termination Controller

This block decides, data phase by data phase, how a PCI target ends a transaction it has claimed. Once the address decoder claims a cycle, the controller drives the target handshakes (device select, target ready and stop). From the access kind, the burst addressing mode, the word position within a 4 KB page, read buffer occupancy, free write buffer words, a delayed-read match flag, a host-side lock flag and an upstream hard-fail flag, it picks one of five outcomes:

- a plain data transfer,
- a disconnect carrying data,
- a disconnect without data,
- a retry,
- a target abort.

Retry and abort are only possible before any data has moved. Disconnects are ordinary flow control and never raise an error indication. Separately, the block checks even parity on write data phases and raises a one-cycle error flag on a mismatch. The data path, buffer storage, address decode and master behaviour live elsewhere.

Top module: `pci_term_ctrl`

## Requirements
- R1: While rst_ni is low and while no transaction is claimed, devsel_n_o, trdy_n_o and stop_n_o are high and par_err_o is low.
- R2: A claim (claim_i high with frame_n_i low at a clock edge) puts the block in the data stage from the next cycle. In that stage devsel_n_o is low for every outcome except abort. A plain transfer shows trdy_n_o low and stop_n_o high, and a phase completes at an edge where irdy_n_i is low.
- R3: On the first data phase, host_lock_i high gives a retry: stop_n_o low, trdy_n_o high, devsel_n_o low. This outcome takes priority over every other one.
- R4: On the first data phase of a read (kind_i code 0), a retry is given when dly_match_i is high or rd_avail_i is zero.
- R5: On the first data phase of a write (kind_i code 1, or code 3), a retry is given when wr_free_i is zero. For memory-write-and-invalidate (kind_i code 2), a retry is given when wr_free_i is below LINE_WORDS.
- R6: On the first data phase of a read with no retry cause, hard_fail_i gives a target abort: devsel_n_o high, stop_n_o low, trdy_n_o high. Writes are never aborted.
- R7: With frame_n_i low, a burst_mode_i other than 0 (0 means linear increment) gives a disconnect with data on the first phase: trdy_n_o and stop_n_o both low.
- R8: With frame_n_i low, a read phase with rd_avail_i equal to 1 ends in a disconnect with data. A later read phase with rd_avail_i zero ends in a disconnect without data.
- R9: With frame_n_i low, a write phase whose page_word_i is all ones (the last word of a 4 KB page) ends in a disconnect with data. A later write phase with wr_free_i zero ends in a disconnect without data.
- R10: After the first data phase, host_lock_i, dly_match_i and hard_fail_i have no effect: no retry and no abort follow.
- R11: Once stop has been signalled and the phase completes with frame_n_i still low, stop_n_o stays low (with devsel_n_o low, or high after an abort) until frame_n_i goes high. After that the outputs return to idle.
- R12: For a write phase that transfers data at edge E1, the expected parity is the XOR of ad_i and cbe_n_i sampled at E1. par_i is sampled at E2. On a mismatch, par_err_o is high for the cycle after E2. Reads are never checked, and a misaligned memory-write-and-invalidate or one with byte enables deasserted is not flagged.
- R13: Retries, disconnects and aborts do not raise par_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| claim_i | input | 1 | Address decode hit during the address phase |
| frame_n_i | input | 1 | Master frame, active low |
| irdy_n_i | input | 1 | Master ready, active low |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 memory-write-and-invalidate, 3 write |
| burst_mode_i | input | 2 | Burst addressing mode, 0 is linear increment |
| page_word_i | input | PWW | Word index of the current data phase within its 4 KB page |
| rd_avail_i | input | CNTW | Words held in the read buffer |
| wr_free_i | input | CNTW | Free words in the posting buffer |
| dly_match_i | input | 1 | Read matches a pending delayed transaction |
| host_lock_i | input | 1 | PCI side locked from the host |
| hard_fail_i | input | 1 | Upstream bus returned a hard fail for this read |
| ad_i | input | DW | Address/data bus |
| cbe_n_i | input | BW | Byte enables, active low |
| par_i | input | 1 | Parity, one cycle after its data |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Stop, active low |
| par_err_o | output | 1 | Write data parity mismatch flag |

## Verification
The first data phase is swept over every combination of access kind, burst mode, lock, delayed match, hard fail, three read buffer levels, three write buffer levels, frame state and page position. This sweep separates the priority order among retry, abort, disconnect and transfer, and it shows that disconnects need frame low. Directed bursts draw down the read buffer, walk up to a page end and empty the write buffer mid-burst, which tells disconnects with data apart from those without. The same bursts raise lock, match and hard fail on later phases to show that these flags are ignored there. Parity is tried with matching and mismatching values on writes and reads, and on a misaligned memory-write-and-invalidate, to separate a real error from silence.

// File: rtl/pci_tt_pkg.sv
package pci_tt_pkg;
  localparam logic [1:0] KIND_READ = 2'd0;
  localparam logic [1:0] KIND_MWI  = 2'd2;

  typedef enum logic [2:0] {
    DEC_XFER,
    DEC_DISC_DATA,
    DEC_DISC_NODATA,
    DEC_RETRY,
    DEC_ABORT
  } dec_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_BACKOFF
  } st_e;
endpackage

// File: rtl/pci_tt_decide.sv
module pci_tt_decide
  import pci_tt_pkg::*;
#(
  parameter int CNTW       = 8,
  parameter int LINE_WORDS = 8,
  parameter int PWW        = 10
) (
  input  logic            first_i,
  input  logic            more_i,
  input  logic [1:0]      kind_i,
  input  logic [1:0]      mode_i,
  input  logic [PWW-1:0]  page_word_i,
  input  logic [CNTW-1:0] rd_avail_i,
  input  logic [CNTW-1:0] wr_free_i,
  input  logic            dly_match_i,
  input  logic            host_lock_i,
  input  logic            hard_fail_i,
  output dec_e            dec_o
);
  localparam logic [CNTW-1:0] NEED_LINE = CNTW'(LINE_WORDS);
  localparam logic [CNTW-1:0] NEED_ONE  = CNTW'(1);

  logic is_rd, is_mwi, rd_empty, rd_last, wr_short, wr_none, page_end, disc_cause;

  always_comb begin
    is_rd      = (kind_i == KIND_READ);
    is_mwi     = (kind_i == KIND_MWI);
    rd_empty   = (rd_avail_i == '0);
    rd_last    = (rd_avail_i == NEED_ONE);
    wr_none    = (wr_free_i == '0);
    wr_short   = wr_free_i < (is_mwi ? NEED_LINE : NEED_ONE);
    page_end   = &page_word_i;
    // early stop is only worth signalling if the master wants more phases
    disc_cause = more_i && ((mode_i != 2'd0) || (is_rd && rd_last) || (!is_rd && page_end));

    dec_o = DEC_XFER;
    if (first_i) begin
      if (host_lock_i)                                       dec_o = DEC_RETRY;
      else if ((is_rd && (dly_match_i || rd_empty)) ||
               (!is_rd && wr_short))                         dec_o = DEC_RETRY;
      else if (is_rd && hard_fail_i)                         dec_o = DEC_ABORT;
      else if (disc_cause)                                   dec_o = DEC_DISC_DATA;
    end else begin
      if ((is_rd && rd_empty) || (!is_rd && wr_none))        dec_o = DEC_DISC_NODATA;
      else if (disc_cause)                                   dec_o = DEC_DISC_DATA;
    end
  end
endmodule

// File: rtl/pci_tt_fsm.sv
module pci_tt_fsm
  import pci_tt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       claim_i,
  input  logic       frame_n_i,
  input  logic       irdy_n_i,
  input  logic [1:0] kind_i,
  input  logic [1:0] mode_i,
  input  dec_e       dec_i,
  output logic [1:0] kind_o,
  output logic [1:0] mode_o,
  output logic       first_o,
  output logic       in_data_o,
  output logic       xfer_o,
  output logic       devsel_n_o,
  output logic       trdy_n_o,
  output logic       stop_n_o
);
  st_e  st_q;
  logic first_q, abort_q;
  logic [1:0] kind_q, mode_q;

  assign kind_o    = kind_q;
  assign mode_o    = mode_q;
  assign first_o   = first_q;
  assign in_data_o = (st_q == ST_DATA);
  // every data-stage outcome drives trdy or stop, so irdy alone closes a phase
  assign xfer_o    = in_data_o && !irdy_n_i && !trdy_n_o;

  always_comb begin
    devsel_n_o = 1'b1;
    trdy_n_o   = 1'b1;
    stop_n_o   = 1'b1;
    unique case (st_q)
      ST_DATA: begin
        devsel_n_o = (dec_i == DEC_ABORT);
        trdy_n_o   = !((dec_i == DEC_XFER) || (dec_i == DEC_DISC_DATA));
        stop_n_o   = (dec_i == DEC_XFER);
      end
      ST_BACKOFF: begin
        devsel_n_o = abort_q;
        stop_n_o   = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      abort_q <= 1'b0;
      kind_q  <= '0;
      mode_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (claim_i && !frame_n_i) begin
          st_q    <= ST_DATA;
          first_q <= 1'b1;
          abort_q <= 1'b0;
          kind_q  <= kind_i;
          mode_q  <= mode_i;
        end
        ST_DATA: if (!irdy_n_i) begin
          first_q <= 1'b0;
          abort_q <= (dec_i == DEC_ABORT);
          if (frame_n_i)      st_q <= ST_IDLE;
          else if (!stop_n_o) st_q <= ST_BACKOFF;
        end
        ST_BACKOFF: if (frame_n_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tt_parity.sv
module pci_tt_parity #(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_xfer_i,
  input  logic [DW-1:0] ad_i,
  input  logic [BW-1:0] cbe_n_i,
  input  logic          par_i,
  output logic          par_err_o
);
  logic chk_q, exp_q, err_q;

  assign par_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      exp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      chk_q <= wr_xfer_i;
      exp_q <= ^{ad_i, cbe_n_i};
      err_q <= chk_q && (par_i != exp_q);
    end
  end
endmodule

// File: rtl/pci_term_ctrl.sv
module pci_term_ctrl
  import pci_tt_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNTW       = 8,
  parameter int LINE_WORDS = 8,
  parameter int PAGE_BYTES = 4096,
  localparam int BW        = DW / 8,
  localparam int WORD_LSB  = $clog2(BW),
  localparam int PAGE_LSB  = $clog2(PAGE_BYTES),
  localparam int PWW       = PAGE_LSB - WORD_LSB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            claim_i,
  input  logic            frame_n_i,
  input  logic            irdy_n_i,
  input  logic [1:0]      kind_i,
  input  logic [1:0]      burst_mode_i,
  input  logic [PWW-1:0]  page_word_i,
  input  logic [CNTW-1:0] rd_avail_i,
  input  logic [CNTW-1:0] wr_free_i,
  input  logic            dly_match_i,
  input  logic            host_lock_i,
  input  logic            hard_fail_i,
  input  logic [DW-1:0]   ad_i,
  input  logic [BW-1:0]   cbe_n_i,
  input  logic            par_i,
  output logic            devsel_n_o,
  output logic            trdy_n_o,
  output logic            stop_n_o,
  output logic            par_err_o
);
  dec_e       dec;
  logic [1:0] kind_q, mode_q;
  logic       first_q, in_data, xfer;

  pci_tt_decide #(.CNTW(CNTW), .LINE_WORDS(LINE_WORDS), .PWW(PWW)) u_decide (
    .first_i     (first_q),
    .more_i      (!frame_n_i),
    .kind_i      (kind_q),
    .mode_i      (mode_q),
    .page_word_i (page_word_i),
    .rd_avail_i  (rd_avail_i),
    .wr_free_i   (wr_free_i),
    .dly_match_i (dly_match_i),
    .host_lock_i (host_lock_i),
    .hard_fail_i (hard_fail_i),
    .dec_o       (dec)
  );

  pci_tt_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .claim_i    (claim_i),
    .frame_n_i  (frame_n_i),
    .irdy_n_i   (irdy_n_i),
    .kind_i     (kind_i),
    .mode_i     (burst_mode_i),
    .dec_i      (dec),
    .kind_o     (kind_q),
    .mode_o     (mode_q),
    .first_o    (first_q),
    .in_data_o  (in_data),
    .xfer_o     (xfer),
    .devsel_n_o (devsel_n_o),
    .trdy_n_o   (trdy_n_o),
    .stop_n_o   (stop_n_o)
  );

  pci_tt_parity #(.DW(DW), .BW(BW)) u_parity (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_xfer_i (xfer && (kind_q != KIND_READ)),
    .ad_i      (ad_i),
    .cbe_n_i   (cbe_n_i),
    .par_i     (par_i),
    .par_err_o (par_err_o)
  );
endmodule

// File: rtl/pci_term_ctrl_chk.sv
module pci_term_ctrl_chk #(
  parameter int DW  = 32,
  parameter int BW  = 4,
  parameter int PWW = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           frame_n_i,
  input logic           irdy_n_i,
  input logic           host_lock_i,
  input logic [PWW-1:0] page_word_i,
  input logic [DW-1:0]  ad_i,
  input logic [BW-1:0]  cbe_n_i,
  input logic           par_i,
  input logic           devsel_n_o,
  input logic           trdy_n_o,
  input logic           stop_n_o,
  input logic           par_err_o,
  input logic [1:0]     kind_q,
  input logic           first_q,
  input logic           in_data
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (devsel_n_o && trdy_n_o && stop_n_o && !par_err_o)
        else $error("handshakes active in reset");
    end
  end

  assert_trdy_needs_devsel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_n_o |-> !devsel_n_o);

  assert_lock_retry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && first_q && host_lock_i) |-> (!stop_n_o && trdy_n_o && !devsel_n_o));

  assert_abort_only_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_n_o && devsel_n_o) |-> (kind_q == 2'd0));

  assert_page_end_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && (kind_q != 2'd0) && (&page_word_i) && !frame_n_i && !trdy_n_o) |-> !stop_n_o);

  assert_late_no_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && !first_q) |-> !devsel_n_o);

  assert_stop_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_n_o && !irdy_n_i && !frame_n_i) |=> !stop_n_o);

  assert_perr_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> (($past(par_i) != $past(^{ad_i, cbe_n_i}, 2)) &&
                   $past(!trdy_n_o && !irdy_n_i, 2)));
endmodule

bind pci_term_ctrl pci_term_ctrl_chk #(.DW(DW), .BW(BW), .PWW(PWW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_n_i   (frame_n_i),
  .irdy_n_i    (irdy_n_i),
  .host_lock_i (host_lock_i),
  .page_word_i (page_word_i),
  .ad_i        (ad_i),
  .cbe_n_i     (cbe_n_i),
  .par_i       (par_i),
  .devsel_n_o  (devsel_n_o),
  .trdy_n_o    (trdy_n_o),
  .stop_n_o    (stop_n_o),
  .par_err_o   (par_err_o),
  .kind_q      (kind_q),
  .first_q     (first_q),
  .in_data     (in_data)
);

// File: tb/pci_term_ctrl_test.sv
module pci_term_ctrl_test;
  localparam int DW = 32, BW = 4, CNTW = 4, LINE = 4, PWW = 10;
  localparam logic [2:0] O_IDLE = 3'b111, O_XFER = 3'b001, O_DISC = 3'b000,
                         O_STOP = 3'b010, O_ABRT = 3'b110;

  logic clk = 0, rst_ni = 0;
  logic claim = 0, frame_n = 1, irdy_n = 1, dly = 0, lock = 0, hf = 0, par = 0;
  logic [1:0] kind = 0, mode = 0;
  logic [PWW-1:0] pw = '0;
  logic [CNTW-1:0] ravail = '0, wfree = '0;
  logic [DW-1:0] ad = '0;
  logic [BW-1:0] cbe = '0;
  logic devsel_n, trdy_n, stop_n, perr;
  int total = 0, failed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_term_ctrl #(.DW(DW), .CNTW(CNTW), .LINE_WORDS(LINE), .PAGE_BYTES(4096)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .claim_i(claim), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
    .kind_i(kind), .burst_mode_i(mode), .page_word_i(pw), .rd_avail_i(ravail),
    .wr_free_i(wfree), .dly_match_i(dly), .host_lock_i(lock), .hard_fail_i(hf),
    .ad_i(ad), .cbe_n_i(cbe), .par_i(par), .devsel_n_o(devsel_n), .trdy_n_o(trdy_n),
    .stop_n_o(stop_n), .par_err_o(perr));

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {devsel_n, trdy_n, stop_n, perr};
  endfunction

  function automatic logic [2:0] exp_first(int k, int m, bit lk, bit dl, bit h,
                                           int ra, int wf, bit fr, bit pe);
    bit rd = (k == 0);
    int need = (k == 2) ? LINE : 1;
    if (lk) return O_STOP;
    if (rd && (dl || ra == 0)) return O_STOP;
    if (!rd && wf < need) return O_STOP;
    if (rd && h) return O_ABRT;
    if (!fr && (m != 0 || (rd && ra == 1) || (!rd && pe))) return O_DISC;
    return O_XFER;
  endfunction

  task automatic start(int k, int m);
    @(negedge clk);
    claim = 1; frame_n = 0; irdy_n = 1; kind = 2'(k); mode = 2'(m);
    @(posedge clk);
  endtask

  task automatic phase(bit fr, int p, int ra, int wf, bit dl, bit lk, bit h);
    @(negedge clk);
    claim = 0; frame_n = fr; irdy_n = 0; pw = PWW'(p);
    ravail = CNTW'(ra); wfree = CNTW'(wf); dly = dl; lock = lk; hf = h;
    #1;
  endtask

  task automatic finish();
    phase(1, 0, 15, 15, 0, 0, 0);
    @(negedge clk);
    irdy_n = 1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", outs(), {O_IDLE, 1'b0});
    @(negedge clk) rst_ni = 1;
    #1 chk("R1 idle", outs(), {O_IDLE, 1'b0});

    // first-phase sweep: priority R3 R4 R5 R6 R7 R8 R9, plus R13
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 2; m++)
        for (int lk = 0; lk < 2; lk++)
          for (int dl = 0; dl < 2; dl++)
            for (int h = 0; h < 2; h++)
              for (int ai = 0; ai < 3; ai++)
                for (int wi = 0; wi < 3; wi++)
                  for (int fr = 0; fr < 2; fr++)
                    for (int pi = 0; pi < 2; pi++) begin
                      int ra = (ai == 0) ? 0 : (ai == 1) ? 1 : 5;
                      int wf = (wi == 0) ? 0 : (wi == 1) ? 1 : LINE;
                      start(k, m);
                      phase(fr[0], pi ? 10'h3FF : 10'h100, ra, wf, dl[0], lk[0], h[0]);
                      chk("R3/R4/R5/R6/R7/R8/R9/R13 first phase", outs(),
                          {exp_first(k, m, lk[0], dl[0], h[0], ra, wf, fr[0], pi[0]), 1'b0});
                      finish();
                      chk("R11 released", outs(), {O_IDLE, 1'b0});
                    end

    // R8 read burst draining buffer, R11 stop held until frame rises
    start(0, 0);
    phase(0, 1, 3, 0, 0, 0, 0); chk("R2 read xfer", outs(), {O_XFER, 1'b0});
    phase(0, 2, 2, 0, 0, 0, 0); chk("R2 read xfer 2", outs(), {O_XFER, 1'b0});
    phase(0, 3, 1, 0, 0, 0, 0); chk("R8 last word disc", outs(), {O_DISC, 1'b0});
    @(negedge clk); irdy_n = 1; #1 chk("R11 backoff stop", outs(), {O_STOP, 1'b0});
    @(negedge clk); #1 chk("R11 backoff held", outs(), {O_STOP, 1'b0});
    @(negedge clk); frame_n = 1; #1 chk("R11 frame rising", outs(), {O_STOP, 1'b0});
    @(negedge clk); #1 chk("R11 back to idle", outs(), {O_IDLE, 1'b0});

    // R10 late flags ignored, R8 empty later read gives stop without data
    start(0, 0);
    phase(0, 1, 5, 0, 0, 0, 0); chk("R2 read first", outs(), {O_XFER, 1'b0});
    phase(0, 2, 5, 0, 1, 1, 1); chk("R10 late lock/match/fail ignored", outs(), {O_XFER, 1'b0});
    phase(0, 3, 0, 0, 0, 0, 0); chk("R8 later empty read", outs(), {O_STOP, 1'b0});
    finish();

    // R9 write walking to page end, and late empty posting buffer
    start(1, 0);
    phase(0, 10'h3FD, 0, 8, 0, 0, 0); chk("R2 write xfer", outs(), {O_XFER, 1'b0});
    phase(0, 10'h3FE, 0, 8, 0, 1, 0); chk("R10 late lock on write", outs(), {O_XFER, 1'b0});
    phase(0, 10'h3FF, 0, 8, 0, 0, 0); chk("R9 page end disc", outs(), {O_DISC, 1'b0});
    finish();
    start(2, 0);
    phase(0, 10'h010, 0, 4, 0, 0, 0); chk("R5 mwi full line", outs(), {O_XFER, 1'b0});
    phase(0, 10'h011, 0, 0, 0, 0, 0); chk("R9 later write no space", outs(), {O_STOP, 1'b0});
    finish();

    // R6 abort with backoff holding devsel high
    start(0, 0);
    phase(0, 1, 5, 0, 0, 0, 1); chk("R6 abort", outs(), {O_ABRT, 1'b0});
    @(negedge clk); irdy_n = 1; #1 chk("R6 R11 abort backoff", outs(), {O_ABRT, 1'b0});
    finish(); chk("R13 abort silent", outs(), {O_IDLE, 1'b0});

    // R12 parity
    ad = 32'h1234_5679; cbe = 4'h0;
    start(1, 0);
    phase(1, 4, 0, 8, 0, 0, 0);
    @(negedge clk); irdy_n = 1; par = ~(^{ad, cbe});
    @(negedge clk); #1 chk("R12 bad write parity", {3'b111, perr}, 4'b1111);
    @(negedge clk); #1 chk("R12 flag one cycle", {3'b111, perr}, 4'b1110);
    start(1, 0);
    phase(1, 4, 0, 8, 0, 0, 0);
    @(negedge clk); irdy_n = 1; par = ^{ad, cbe};
    @(negedge clk); #1 chk("R12 good write parity", {3'b111, perr}, 4'b1110);
    start(0, 0);
    phase(1, 4, 5, 0, 0, 0, 0);
    @(negedge clk); irdy_n = 1; par = ~(^{ad, cbe});
    @(negedge clk); #1 chk("R12 read not checked", {3'b111, perr}, 4'b1110);
    ad = 32'h0000_0F02; cbe = 4'b0101;
    start(2, 0);
    phase(1, 10'h003, 0, 4, 0, 0, 0); chk("R12 misaligned mwi accepted", outs(), {O_XFER, 1'b0});
    @(negedge clk); irdy_n = 1; par = ^{ad, cbe};
    @(negedge clk); #1 chk("R12 misaligned mwi not flagged", {3'b111, perr}, 4'b1110);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule